// File: doc/BRIEF.md
# Pipelined Double-Precision Magnitude Adder/Subtractor

This block combines the magnitudes of two 64-bit binary floating-point operands (sign in bit 63, 11-bit exponent with bias 1023, 52-bit fraction with a hidden leading 1). It either adds the magnitudes or subtracts the second from the first, as selected by an effective-operation input. The sign routing that turns a signed add or subtract into one of these two operations is done outside the block. For that reason the sign of operand B never enters the result.

The work flows through a six-register pipeline:
1. Order the operands by magnitude.
2. Align the smaller mantissa in a window wider than twice the mantissa, so that the guard, round and sticky information survives.
3. Add or subtract.
4. Renormalize right on carry-out.
5. Renormalize left after cancellation.
6. Round to nearest even, with a final one-place shift when rounding carries out.

A new operation may enter on every clock. A valid bit and two exception flags (not-a-number, infinity), produced by a separate exception path, travel alongside the data.

Top module: `fp64_addsub_pipe`

## Requirements
- R1: With the operation input low, the result equals sign(A) times (|A| + |B|), rounded to nearest even. The result is packed with sign in bit 63, exponent in bits 62:52 and fraction in bits 51:0.
- R2: With the operation input high, the result equals sign(A) times (|A| - |B|), so it is negative-of-A's-sign when |B| > |A|. The sign bit of B never affects the result.
- R3: When the exponent difference exceeds the alignment window, the smaller operand contributes only a sticky bit. The result is still the correctly rounded value.
- R4: Rounding is to nearest with ties to even. It is decided from the guard, round and sticky bits below the result's last fraction bit.
- R5: When rounding carries out of the mantissa, the mantissa is shifted right once and the exponent is raised by one.
- R6: After cancellation in a subtraction, the sum is shifted left by its leading-zero count and the exponent is lowered by the same amount.
- R7: Three cases produce +0, encoded as all 64 bits zero: an exact zero result, a result below the smallest normal number, and a result formed from operands with exponent field 0. Operands with exponent field 0 are treated as zero.
- R8: A rounded exponent of 2047 or more yields infinity: exponent field all ones, fraction zero, and the computed sign.
- R9: Each accepted operation appears at the output exactly 6 clocks after its valid strobe. Operations may be issued on consecutive clocks, and the output valid is never raised without a matching input.
- R10: The not-a-number and infinity flag inputs are delivered on the outputs together with the result of the same operation. They are low whenever the output valid is low.
- R11: While reset is asserted, the output valid and both flag outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_a | input | 64 | First operand; its sign sets the result sign |
| in_b | input | 64 | Second operand; its sign is ignored |
| in_sub | input | 1 | 0 adds magnitudes, 1 subtracts |B| from |A| |
| in_nan | input | 1 | Not-a-number flag from the exception path |
| in_inf | input | 1 | Infinity flag from the exception path |
| out_valid | output | 1 | Result strobe |
| out_result | output | 64 | Packed result |
| out_nan | output | 1 | Delayed not-a-number flag |
| out_inf | output | 1 | Delayed infinity flag |

## Verification
Random operand pairs are generated in four groups, and each group exposes a different part of the datapath:
- Exponents drawn independently mostly take the sticky-only path.
- Exponents within a few places of each other exercise alignment shifts with live guard and round bits.
- Exponents within sixty places cover the edge of the alignment window.
- Equal exponents with nearly equal fractions force deep left normalization and exact cancellation.

Directed pairs then isolate single behaviours: halfway ties with even and odd last bits, a tie whose round-up carries out of the mantissa, subtraction of a negligible operand, results in the denormal range, exponent overflow to infinity, and a negative B sign that must be ignored. Expected values come from real arithmetic in the bench, with the flush-to-zero and +0 rules applied afterwards.

// File: rtl/fp64_addsub_pipe.sv
module fp64_addsub_pipe #(
  parameter int EW = 11,
  parameter int FW = 52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [EW+FW:0]    in_a,
  input  logic [EW+FW:0]    in_b,
  input  logic              in_sub,
  input  logic              in_nan,
  input  logic              in_inf,
  output logic              out_valid,
  output logic [EW+FW:0]    out_result,
  output logic              out_nan,
  output logic              out_inf
);
  localparam int W    = EW + FW + 1;
  localparam int MW   = FW + 1;
  localparam int XW   = MW + 3;
  localparam int AW   = MW + XW;
  localparam int LZW  = $clog2(XW + 1);
  localparam int LAT  = 6;
  localparam int EMAX = (1 << EW) - 1;

  logic [LAT-1:0] v, fn, fi;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v  <= '0;
      fn <= '0;
      fi <= '0;
    end else begin
      v  <= {v[LAT-2:0], in_valid};
      fn <= {fn[LAT-2:0], in_valid & in_nan};
      fi <= {fi[LAT-2:0], in_valid & in_inf};
    end
  assign out_valid = v[LAT-1];
  assign out_nan   = fn[LAT-1];
  assign out_inf   = fi[LAT-1];

  // stage 1: flush, order by magnitude, exponent difference
  logic [W-2:0] ka, kb, kl, ks;
  logic swap;
  assign ka   = (in_a[W-2:FW] == '0) ? '0 : in_a[W-2:0];
  assign kb   = (in_b[W-2:FW] == '0) ? '0 : in_b[W-2:0];
  assign swap = kb > ka;
  assign kl   = swap ? kb : ka;
  assign ks   = swap ? ka : kb;

  logic [EW-1:0] e1, d1;
  logic [MW-1:0] ml1, ms1;
  logic          sub1, sg1;
  always_ff @(posedge clk) begin
    e1   <= kl[W-2:FW];
    d1   <= kl[W-2:FW] - ks[W-2:FW];
    ml1  <= {|kl[W-2:FW], kl[FW-1:0]};
    ms1  <= {|ks[W-2:FW], ks[FW-1:0]};
    sub1 <= in_sub;
    sg1  <= in_a[W-1] ^ (in_sub & swap);
  end

  // stage 2: alignment in a lossless window, guard/round/sticky
  logic [AW-1:0] win;
  logic [XW-1:0] al;
  assign win = {ms1, XW'(0)} >> d1;
  assign al  = (d1 > EW'(XW)) ? {(XW-1)'(0), |ms1}
                              : {win[AW-1 -: MW+2], |win[XW-3:0]};

  logic [EW-1:0] e2;
  logic [XW-1:0] ml2, ms2;
  logic          sub2, sg2;
  always_ff @(posedge clk) begin
    e2   <= e1;
    ml2  <= {ml1, 3'b000};
    ms2  <= al;
    sub2 <= sub1;
    sg2  <= sg1;
  end

  // stage 3: mantissa add or subtract
  logic [XW:0]   sum3;
  logic [EW-1:0] e3;
  logic          sg3;
  always_ff @(posedge clk) begin
    sum3 <= sub2 ? {1'b0, ml2} - {1'b0, ms2} : {1'b0, ml2} + {1'b0, ms2};
    e3   <= e2;
    sg3  <= sg2;
  end

  // stage 4: right normalization on carry-out
  logic [XW-1:0] n4;
  logic [EW:0]   e4;
  logic          sg4;
  always_ff @(posedge clk) begin
    n4  <= sum3[XW] ? {sum3[XW:2], |sum3[1:0]} : sum3[XW-1:0];
    e4  <= {1'b0, e3} + (EW+1)'(sum3[XW]);
    sg4 <= sg3;
  end

  // stage 5: left normalization after cancellation
  logic [LZW-1:0] lz;
  always_comb begin
    lz = '0;
    for (int i = 0; i < XW; i++)
      if (n4[i]) lz = LZW'(XW - 1 - i);
  end

  logic [XW-1:0] n5;
  logic [EW:0]   e5;
  logic          sg5, z5;
  always_ff @(posedge clk) begin
    n5  <= n4 << lz;
    e5  <= e4 - (EW+1)'(lz);
    z5  <= (n4 == '0) || (e4 <= (EW+1)'(lz));
    sg5 <= sg4;
  end

  // stage 6: round to nearest even, renormalize on round carry
  logic          inc, ovf;
  logic [MW:0]   rm;
  logic [MW-1:0] mant;
  logic [EW:0]   ef;
  assign inc  = n5[2] & (n5[1] | n5[0] | n5[3]);
  assign rm   = {1'b0, n5[XW-1:3]} + (MW+1)'(inc);
  assign ovf  = rm[MW];
  assign mant = ovf ? rm[MW:1] : rm[MW-1:0];
  assign ef   = e5 + (EW+1)'(ovf);

  always_ff @(posedge clk)
    if (z5)
      out_result <= '0;
    else if (ef >= (EW+1)'(EMAX))
      out_result <= {sg5, {EW{1'b1}}, FW'(0)};
    else
      out_result <= {sg5, ef[EW-1:0], mant[FW-1:0]};
endmodule

// File: rtl/fp64_addsub_pipe_chk.sv
module fp64_addsub_pipe_chk #(
  parameter int EW = 11,
  parameter int FW = 52
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_nan,
  input logic           in_inf,
  input logic           out_valid,
  input logic [EW+FW:0] out_result,
  input logic           out_nan,
  input logic           out_inf
);
  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd7) |-> (out_valid == $past(in_valid, 6)));

  assert_flags_need_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_nan || out_inf) |-> out_valid);

  assert_nan_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd7) |-> (out_nan == $past(in_valid && in_nan, 6)));

  assert_inf_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd7) |-> (out_inf == $past(in_valid && in_inf, 6)));

  assert_zero_form_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_result[EW+FW-1:FW] == '0) |-> (out_result == '0));

  assert_inf_form_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (&out_result[EW+FW-1:FW])) |-> (out_result[FW-1:0] == '0));
endmodule

bind fp64_addsub_pipe fp64_addsub_pipe_chk #(.EW(EW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_nan(in_nan), .in_inf(in_inf),
  .out_valid(out_valid), .out_result(out_result), .out_nan(out_nan), .out_inf(out_inf)
);

// File: tb/test_fp64_addsub_pipe.sv
`timescale 1ns/1ps
module test_fp64_addsub_pipe;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_a = '0, in_b = '0;
  logic        in_sub = 1'b0, in_nan = 1'b0, in_inf = 1'b0;
  logic        out_valid, out_nan, out_inf;
  logic [63:0] out_result;

  fp64_addsub_pipe i_fp64_addsub_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_sub(in_sub), .in_nan(in_nan), .in_inf(in_inf),
    .out_valid(out_valid), .out_result(out_result), .out_nan(out_nan), .out_inf(out_inf)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [63:0] q_res[$];
  logic [1:0]  q_flg[$];
  string       q_tag[$];
  time         q_t[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_op(input logic [63:0] a, input logic [63:0] b, input logic sub);
    real ma, mb, r;
    logic [63:0] ra;
    ma = (a[62:52] == 11'd0) ? 0.0 : $bitstoreal({1'b0, a[62:0]});
    mb = (b[62:52] == 11'd0) ? 0.0 : $bitstoreal({1'b0, b[62:0]});
    r  = sub ? ma - mb : ma + mb;
    if (a[63]) r = -r;
    ra = $realtobits(r);
    if (ra[62:52] == 11'd0) ra = 64'h0;
    return ra;
  endfunction

  task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic sub,
                       input logic nan, input logic inf, input string tag);
    in_a = a; in_b = b; in_sub = sub; in_nan = nan; in_inf = inf; in_valid = 1'b1;
    q_res.push_back(ref_op(a, b, sub));
    q_flg.push_back({nan, inf});
    q_tag.push_back(tag);
    q_t.push_back($time);
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 1'b0; in_nan = 1'b0; in_inf = 1'b0;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_res.size() == 0) begin
        chk(1'b0, "R9 unexpected output", {63'd0, out_valid}, 64'd0);
      end else begin
        logic [63:0] er;
        logic [1:0]  ef;
        string       tg;
        time         t0;
        er = q_res.pop_front(); ef = q_flg.pop_front();
        tg = q_tag.pop_front(); t0 = q_t.pop_front();
        chk(out_result === er, tg, out_result, er);
        chk({out_nan, out_inf} === ef, "R10 flags", {62'd0, out_nan, out_inf}, {62'd0, ef});
        chk(($time - t0) == 60, "R9 latency", 64'($time - t0), 64'd60);
      end
    end
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog act=%h exp=%h", 64'd1, 64'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk({out_valid, out_nan, out_inf} === 3'b000, "R11 reset outputs",
        {61'd0, out_valid, out_nan, out_inf}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    issue(64'h3FF0000000000000, 64'h3FF0000000000000, 1'b0, 1'b0, 1'b0, "R1 1+1");
    issue(64'h3FF0000000000000, 64'h3CA0000000000000, 1'b0, 1'b0, 1'b0, "R4 tie even stays");
    issue(64'h3FF0000000000001, 64'h3CA0000000000000, 1'b0, 1'b0, 1'b0, "R4 tie odd rounds up");
    issue(64'h3FF0000000000000, 64'h3CA8000000000000, 1'b0, 1'b0, 1'b0, "R4 above half");
    issue(64'h3FFFFFFFFFFFFFFF, 64'h3CA0000000000000, 1'b0, 1'b0, 1'b0, "R5 round carry");
    issue(64'h3FF0000000000000, 64'h39B0000000000000, 1'b1, 1'b0, 1'b0, "R3 sticky only sub");
    issue(64'h3FF0000000000000, 64'h3C90000000000000, 1'b1, 1'b0, 1'b0, "R3 window edge sub");
    issue(64'h3FF0000000000001, 64'h3FF0000000000000, 1'b1, 1'b0, 1'b0, "R6 deep cancel");
    issue(64'h4000000000000000, 64'h3FFFFFFFFFFFFFFF, 1'b1, 1'b0, 1'b0, "R6 one-place cancel");
    issue(64'hBFF0000000000000, 64'h3FF0000000000000, 1'b1, 1'b0, 1'b0, "R7 exact zero");
    issue(64'h000FFFFFFFFFFFFF, 64'h3FF0000000000000, 1'b0, 1'b0, 1'b0, "R7 denormal input");
    issue(64'h0010000000000001, 64'h0010000000000000, 1'b1, 1'b0, 1'b0, "R7 underflow");
    issue(64'h7FEFFFFFFFFFFFFF, 64'h7FEFFFFFFFFFFFFF, 1'b0, 1'b0, 1'b0, "R8 overflow");
    issue(64'hFFEFFFFFFFFFFFFF, 64'h7FE0000000000000, 1'b0, 1'b0, 1'b0, "R8 negative overflow");
    issue(64'h3FF0000000000000, 64'h4000000000000000, 1'b1, 1'b0, 1'b0, "R2 |B|>|A|");
    issue(64'h3FF0000000000000, 64'hC000000000000000, 1'b0, 1'b0, 1'b0, "R2 B sign ignored");
    issue(64'h4008000000000000, 64'h3FF0000000000000, 1'b0, 1'b1, 1'b0, "R10 nan flag");
    issue(64'h4008000000000000, 64'h3FF0000000000000, 1'b1, 1'b0, 1'b1, "R10 inf flag");
    idle();
    chk(q_res.size() <= 6, "R9 queue depth", 64'(q_res.size()), 64'd6);
    repeat (8) idle();

    for (int i = 0; i < 3000; i++) begin
      logic [10:0] ea, eb;
      logic [51:0] fa, fb;
      int t, mode;
      ea = 11'($urandom_range(2046, 1));
      fa = 52'({$urandom(), $urandom()});
      fb = 52'({$urandom(), $urandom()});
      mode = $urandom_range(3, 0);
      t = int'(ea);
      case (mode)
        0: t = $urandom_range(2046, 1);
        1: t = int'(ea) + $urandom_range(6, 0) - 3;
        2: t = int'(ea) + $urandom_range(120, 0) - 60;
        default: begin t = int'(ea); fb = fa ^ 52'($urandom_range(255, 0)); end
      endcase
      if (t < 1) t = 1;
      if (t > 2046) t = 2046;
      eb = 11'(t);
      if ($urandom_range(31, 0) == 0) ea = 11'd0;
      if ($urandom_range(31, 0) == 0) eb = 11'd0;
      begin
        logic sb;
        sb = 1'($urandom());
        issue({1'($urandom()), ea, fa}, {1'($urandom()), eb, fb}, sb,
              1'($urandom_range(15, 0) == 0), 1'($urandom_range(15, 0) == 0),
              sb ? "R2 random sub" : "R1 random add");
      end
      if ($urandom_range(3, 0) == 0) idle();
    end
    repeat (20) idle();
    chk(q_res.size() == 0, "R9 all results delivered", 64'(q_res.size()), 64'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule